// File: doc/BRIEF.md
# Flash Erase Algorithm Sequencer

This block runs the complete bulk-erase procedure for a byte-wide flash device that takes its commands as bus writes. On a start request it first has an external program engine clear every byte to 00h, so that all cells begin the erase from the same charge state. It then alternates erase pulses with a byte-by-byte verify walk, and finishes once the last address reads back as erased or the pulse budget runs out.

Every flash access goes through a single request/acknowledge bus port. An erase pulse is two writes of the erase command followed by a long settle time. A verify step is a write of the verify command carrying the target address, a short settle time, and a read of that byte. When a byte fails, the walk keeps its position: one more pulse is issued and the same byte is read again. A single pulse counter covers the whole erase. At the end the device is returned to read mode, and a done flag is raised together with either pass or fail.

Top module: `fes_erase_seq`

## Requirements
- R1: After reset, done_o, pass_o, fail_o, bus_req_o and pre_start_o are all low.
- R2: A start request raises pre_start_o and holds it until pre_done_i. No bus request is made while pre_start_o is high.
- R3: An erase pulse is two consecutive acknowledged writes of data 20h, followed by at least ERASE_WAIT idle cycles before the next verify write.
- R4: A verify step is an acknowledged write of A0h with the target address, then at least VERIFY_WAIT cycles, then a read (bus_we_o low) of that same address.
- R5: A verify read returning FFh passes. The next verify then targets the next higher address, and the walk starts at address 0.
- R6: A verify read returning any value other than FFh is followed by a new erase pulse and a verify of the same address, never a restart from address 0.
- R7: At most MAX_PULSES erase pulses are issued per run. A failing verify once that many pulses have been issued ends the run with fail.
- R8: Every run ends with a write of 00h and then done_o high with exactly one of pass_o and fail_o. pass_o is set only when address LAST_ADDR has read back FFh.
- R9: A start request is ignored while a run is in progress: the program-engine request is not repeated and the run completes unchanged.
- R10: Once bus_req_o is raised, it and bus_we_o, bus_addr_o and bus_wdata_o stay stable until bus_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start an erase run (accepted only when idle or finished) |
| pre_start_o | output | 1 | Request to the program engine to clear all bytes to 00h |
| pre_done_i | input | 1 | Program engine has finished |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transaction byte address |
| bus_wdata_o | output | 8 | Write data / command byte |
| bus_ack_i | input | 1 | Transaction acknowledge (completes in the cycle seen with bus_req_o) |
| bus_rdata_i | input | 8 | Read data, valid with bus_ack_i |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with every byte erased |
| fail_o | output | 1 | Run finished with the pulse limit exhausted |

## Verification
The assertions assume that bus_ack_i is raised only while bus_req_o is high and lasts for exactly one handshake edge, and that pre_done_i arrives only while pre_start_o is high. The bench's bus responder acknowledges after 0 to 2 wait cycles and drops the acknowledge right after the handshake edge. Its program-engine model answers each request exactly once. The flash model erases a byte once the global pulse count reaches a per-byte threshold. The thresholds are chosen to exercise first-pulse success, failures in the middle of the walk, failures at the last address, a pass exactly at the limit, and a failure beyond the limit.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_EVERIFY = 8'hA0;
    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] BYTE_ERASED = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_ERS1,
        S_ERS2,
        S_EWAIT,
        S_VSET,
        S_VWAIT,
        S_VRD,
        S_RDCMD,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic       we;
        logic [7:0] data;
    } bus_op_t;

    function automatic logic is_erased(input logic [7:0] b);
        return b == BYTE_ERASED;
    endfunction

endpackage

// File: rtl/fes_bus_port.sv
module fes_bus_port
    import fes_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  bus_op_t           op_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    input  logic              bus_ack_i,
    output logic              xfer_done_o
);

    bus_op_t           op_q;
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            op_q   <= '0;
            addr_q <= '0;
        end else if (req_q) begin
            if (bus_ack_i) req_q <= 1'b0;
        end else if (issue_i) begin
            req_q  <= 1'b1;
            op_q   <= op_i;
            addr_q <= addr_i;
        end
    end

    assign bus_req_o   = req_q;
    assign bus_we_o    = op_q.we;
    assign bus_wdata_o = op_q.data;
    assign bus_addr_o  = addr_q;
    assign xfer_done_o = req_q & bus_ack_i;

endmodule

// File: rtl/fes_timer.sv
module fes_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load_i)         cnt_q <= val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/fes_pulse_ctr.sv
module fes_pulse_ctr #(
    parameter int MAX_PULSES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);

    localparam int CW = $clog2(MAX_PULSES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)               cnt_q <= '0;
        else if (inc_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit_o = (cnt_q == LIMIT);

endmodule

// File: rtl/fes_erase_seq.sv
module fes_erase_seq
    import fes_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int LAST_ADDR   = (1 << 18) - 1,
    parameter int ERASE_WAIT  = 1_000_000,
    parameter int VERIFY_WAIT = 600,
    parameter int MAX_PULSES  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              pre_start_o,
    input  logic              pre_done_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [7:0]        bus_rdata_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);

    localparam int MAXW = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
    localparam int TW   = $clog2(MAXW + 1);
    localparam logic [TW-1:0]     EW_T   = TW'(ERASE_WAIT);
    localparam logic [TW-1:0]     VW_T   = TW'(VERIFY_WAIT);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              pass_q, pass_d;
    logic              launched_q;
    logic              issue, xfer_done;
    bus_op_t           op;
    logic              tmr_load, tmr_expired;
    logic [TW-1:0]     tmr_val;
    logic              ctr_clr, ctr_inc, at_limit;

    fes_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .clk        (clk),
        .rst        (rst),
        .issue_i    (issue),
        .op_i       (op),
        .addr_i     (addr_q),
        .bus_req_o  (bus_req_o),
        .bus_we_o   (bus_we_o),
        .bus_addr_o (bus_addr_o),
        .bus_wdata_o(bus_wdata_o),
        .bus_ack_i  (bus_ack_i),
        .xfer_done_o(xfer_done)
    );

    fes_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (tmr_load),
        .val_i    (tmr_val),
        .expired_o(tmr_expired)
    );

    fes_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (ctr_clr),
        .inc_i     (ctr_inc),
        .at_limit_o(at_limit)
    );

    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        pass_d   = pass_q;
        issue    = 1'b0;
        op.we    = 1'b1;
        op.data  = CMD_READ;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (start_i) begin
                    state_d = S_PRE;
                    addr_d  = '0;
                    pass_d  = 1'b0;
                    ctr_clr = 1'b1;
                end
            end
            S_PRE: begin
                if (pre_done_i) state_d = S_ERS1;
            end
            S_ERS1: begin
                op.data = CMD_ERASE;
                issue   = !launched_q;
                if (xfer_done) state_d = S_ERS2;
            end
            S_ERS2: begin
                op.data = CMD_ERASE;
                issue   = !launched_q;
                if (xfer_done) begin
                    ctr_inc  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = EW_T;
                    state_d  = S_EWAIT;
                end
            end
            S_EWAIT: begin
                if (tmr_expired) state_d = S_VSET;
            end
            S_VSET: begin
                op.data = CMD_EVERIFY;
                issue   = !launched_q;
                if (xfer_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = VW_T;
                    state_d  = S_VWAIT;
                end
            end
            S_VWAIT: begin
                if (tmr_expired) state_d = S_VRD;
            end
            S_VRD: begin
                op.we = 1'b0;
                issue = !launched_q;
                if (xfer_done) begin
                    if (is_erased(bus_rdata_i)) begin
                        if (addr_q == LAST_A) begin
                            pass_d  = 1'b1;
                            state_d = S_RDCMD;
                        end else begin
                            addr_d  = addr_q + 1'b1;
                            state_d = S_VSET;
                        end
                    end else if (at_limit) begin
                        pass_d  = 1'b0;
                        state_d = S_RDCMD;
                    end else begin
                        state_d = S_ERS1;
                    end
                end
            end
            S_RDCMD: begin
                op.data = CMD_READ;
                issue   = !launched_q;
                if (xfer_done) state_d = S_DONE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            addr_q     <= '0;
            pass_q     <= 1'b0;
            launched_q <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            pass_q  <= pass_d;
            if (xfer_done)  launched_q <= 1'b0;
            else if (issue) launched_q <= 1'b1;
        end
    end

    assign pre_start_o = (state_q == S_PRE);
    assign done_o      = (state_q == S_DONE);
    assign pass_o      = done_o &  pass_q;
    assign fail_o      = done_o & !pass_q;

endmodule

// File: rtl/fes_erase_seq_chk.sv
module fes_erase_seq_chk #(
    parameter int ADDR_W     = 18,
    parameter int MAX_PULSES = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              pre_start_o,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [7:0]        bus_wdata_o,
    input logic              bus_ack_i,
    input logic              done_o,
    input logic              pass_o,
    input logic              fail_o
);

    int   n_erase_wr;
    logic half_pulse;

    always_ff @(posedge clk) begin
        if (rst || pre_start_o) begin
            n_erase_wr <= 0;
            half_pulse <= 1'b0;
        end else if (bus_req_o && bus_ack_i && bus_we_o && bus_wdata_o == 8'h20) begin
            n_erase_wr <= n_erase_wr + 1;
            half_pulse <= !half_pulse;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !done_o && !bus_req_o && !pre_start_o);

    a_r2_no_bus_in_pre: assert property (@(posedge clk) disable iff (rst)
        pre_start_o |-> !bus_req_o);

    a_r3_pulse_pairs: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && half_pulse) |-> (bus_we_o && bus_wdata_o == 8'h20));

    a_r7_pulse_budget: assert property (@(posedge clk) disable iff (rst)
        n_erase_wr <= 2 * MAX_PULSES);

    a_r8_one_verdict: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $onehot({pass_o, fail_o}));

    a_r8_verdict_only_when_done: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> !pass_o && !fail_o);

    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_ack_i) |=> bus_req_o && $stable(bus_we_o)
            && $stable(bus_addr_o) && $stable(bus_wdata_o));

endmodule

bind fes_erase_seq fes_erase_seq_chk #(.ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pre_start_o(pre_start_o),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_ack_i  (bus_ack_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o)
);

// File: tb/tb_fes_erase_seq.sv
`timescale 1ns/1ps
module tb_fes_erase_seq;

    localparam int AW = 18;
    localparam int LA = 7;
    localparam int EW = 20;
    localparam int VW = 4;
    localparam int MP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          pre_start;
    logic          pre_done = 1'b0;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_ack = 1'b0;
    logic [7:0]    bus_rdata;
    logic          done, pass, fail;

    always #2.5 clk = ~clk;

    fes_erase_seq #(.ADDR_W(AW), .LAST_ADDR(LA), .ERASE_WAIT(EW),
                    .VERIFY_WAIT(VW), .MAX_PULSES(MP)) dut (
        .clk(clk), .rst(rst), .start_i(start),
        .pre_start_o(pre_start), .pre_done_i(pre_done),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
        .done_o(done), .pass_o(pass), .fail_o(fail));

    int total = 0;
    int bad   = 0;

    // flash model: byte a reads FFh once the pulse count reaches need[a]
    int need [0:LA];
    assign bus_rdata = (pulses >= need[bus_addr[2:0]]) ? 8'hFF : 8'h00;

    // monitor state (cleared through mon_clr)
    logic mon_clr = 1'b0;
    int   cyc = 0, pulses = 0, n_read = 0, n_pre = 0, order_err = 0, wait_err = 0;
    int   pre_bus = 0, hold_err = 0, addr_err = 0, t_pulse = 0, t_v = 0;
    logic armed = 0, after_pulse = 0, first_rd = 1, last_ok = 0, pre_q = 0;
    logic [AW-1:0] last_a = '0, v_addr = '0, p_addr = '0;
    logic [7:0]    last_w = 8'hAA;
    logic          p_req = 0, p_ack = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr || rst) begin
            pulses <= 0; n_read <= 0; n_pre <= 0; order_err <= 0; wait_err <= 0;
            pre_bus <= 0; hold_err <= 0; addr_err <= 0; armed <= 0; after_pulse <= 0;
            first_rd <= 1; last_ok <= 0; pre_q <= 0; last_w <= 8'hAA; p_req <= 0; p_ack <= 0;
        end else begin
            pre_q <= pre_start;
            if (pre_start && !pre_q) n_pre <= n_pre + 1;
            if (pre_start && bus_req) pre_bus <= pre_bus + 1;
            // R10: request and payload hold until acknowledged
            if (p_req && !p_ack && (!bus_req || bus_addr != p_addr)) hold_err <= hold_err + 1;
            p_req <= bus_req; p_ack <= bus_ack; p_addr <= bus_addr;
            if (bus_req && bus_ack) begin
                if (bus_we) begin
                    last_w <= bus_wdata;
                    if (bus_wdata == 8'h20) begin
                        if (armed) begin
                            pulses <= pulses + 1; armed <= 0; t_pulse <= cyc; after_pulse <= 1;
                        end else armed <= 1;
                    end else armed <= 0;
                    if (bus_wdata == 8'hA0) begin
                        v_addr <= bus_addr; t_v <= cyc;
                        if (after_pulse && (cyc - t_pulse) < EW) wait_err <= wait_err + 1;
                        after_pulse <= 0;
                    end
                end else begin
                    n_read <= n_read + 1;
                    if (bus_addr != v_addr || (cyc - t_v) < VW) wait_err <= wait_err + 1;
                    if (bus_addr > LA) addr_err <= addr_err + 1;
                    if (bus_addr != (first_rd ? '0 : (last_ok ? last_a + 1'b1 : last_a)))
                        order_err <= order_err + 1;
                    first_rd <= 0;
                    last_a   <= bus_addr;
                    last_ok  <= (bus_rdata == 8'hFF);
                end
            end
        end
    end

    // bus responder: 0..2 wait cycles, rotating
    int lat = 0, lsel = 1;
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack <= 1'b0;
            lsel    <= (lsel == 2) ? 0 : lsel + 1;
            lat     <= lsel;
        end else if (bus_req) begin
            if (lat == 0) bus_ack <= 1'b1;
            else          lat <= lat - 1;
        end
    end

    // program engine model: answers once after 5 cycles
    int pcnt = 0;
    always @(negedge clk) begin
        pre_done <= 1'b0;
        if (pre_start && !pre_done) begin
            if (pcnt == 4) begin pre_done <= 1'b1; pcnt <= 0; end
            else pcnt <= pcnt + 1;
        end
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic set_need(input int dflt);
        for (int i = 0; i <= LA; i++) need[i] = dflt;
    endtask

    // runs one erase; extra_start > 0 pulses start again that many cycles in
    task automatic do_run(input int extra_start);
        int n;
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done || n < 3) begin
            @(negedge clk);
            n++;
            if (extra_start > 0 && n == extra_start) start = 1'b1;
            else start = 1'b0;
            if (n > 20000) break;
        end
        chk(n <= 20000, "watchdog: run did not finish", n, 20000);
    endtask

    task automatic check_run(input string tag, input logic exp_pass,
                             input int exp_pulses, input int exp_reads);
        chk(pass == exp_pass && fail == !exp_pass && done, {tag, " R8 verdict"}, int'(pass), int'(exp_pass));
        chk(last_w == 8'h00, {tag, " R8 final read command"}, int'(last_w), 0);
        chk(pulses == exp_pulses, {tag, " R3/R7 pulse count"}, pulses, exp_pulses);
        chk(n_read == exp_reads, {tag, " R5/R6 verify reads"}, n_read, exp_reads);
        chk(order_err == 0 && addr_err == 0, {tag, " R5/R6 verify order"}, order_err + addr_err, 0);
        chk(wait_err == 0, {tag, " R3/R4 waits and address"}, wait_err, 0);
        chk(n_pre == 1 && pre_bus == 0, {tag, " R2 program-engine phase"}, n_pre * 100 + pre_bus, 100);
        chk(hold_err == 0, {tag, " R10 request hold"}, hold_err, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!done && !pass && !fail, "R1 reset verdict outputs", int'({done, pass, fail}), 0);
        chk(!bus_req && !pre_start, "R1 reset requests", int'({bus_req, pre_start}), 0);
    endtask

    task automatic t_single_pulse();
        set_need(1);
        do_run(0);
        // one pulse erases all 8 bytes: 8 reads
        check_run("single", 1'b1, 1, 8);
    endtask

    task automatic t_mixed_with_restart();
        set_need(1);
        need[1] = 3; need[3] = 2; need[6] = 4;
        do_run(40);                          // R9: start mid-run ignored
        // final pulses = 4, each extra pulse costs one failed read: 8 + 3
        check_run("mixed R9", 1'b1, 4, 11);
    endtask

    task automatic t_last_addr_slow();
        set_need(1);
        need[7] = 5;
        do_run(0);
        check_run("last-addr R6", 1'b1, 5, 12);
    endtask

    task automatic t_limit_exact();
        set_need(1);
        need[0] = MP;
        do_run(0);
        // passes on the last allowed pulse: 8 + 5 reads
        check_run("limit-exact R7", 1'b1, MP, 8 + MP - 1);
    endtask

    task automatic t_limit_exceeded();
        set_need(1);
        need[2] = MP + 3;
        do_run(0);
        // two passing reads, then MP failing reads at address 2
        check_run("limit-over R7", 1'b0, MP, 2 + MP);
    endtask

    initial begin
        for (int i = 0; i <= LA; i++) need[i] = 1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_pulse();
        t_mixed_with_restart();
        t_last_addr_slow();
        t_limit_exact();
        t_limit_exceeded();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule